// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block gathers single-cycle interrupt events from a group of sources, holds each as a pending flag and raises one request line toward the processor. When the processor runs an interrupt-acknowledge cycle, the block answers with the 8-bit vector of its highest-ranked pending source and a transfer acknowledge. If it has nothing to offer, it passes the acknowledge down a priority chain to the next device instead.

One parameter sets the number of sources and a second selects how they are ranked. The receive group uses nine sources: eight message-valid events plus one parity-error event. In that group the rank of every source is programmable. The transmit group uses six sources: a FIFO-empty and an end-of-transmission event for each of three channels, in a fixed order. The vector numbers and the rank values come in as buses from the surrounding register file. The host clears a pending flag through a per-source clear pulse.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A high bit on `cause_set` sets that source's pending flag at the next clock edge. `irq_req` is high in the following cycle and stays high while any flag is pending.
- R2: A high bit on `cause_clr` drops that source's pending flag at the next edge. If the same source sees a set and a clear in the same cycle, the set wins.
- R3: The acknowledge cycle starts when `iack_n` is first sampled low. If `iei_n` is low and a flag is pending at that moment, then from the next cycle until the cycle ends `dtack_n` is low, `vec_oe` is high and `ieo_n` is high. In the same window `vec_o` carries the winning source's vector, which is slice `vec_tbl[8*i +: 8]` for source i. At all other times `vec_o` is zero.
- R4: The winning source's pending flag is cleared at the edge that starts the acknowledge cycle. Other pending flags are kept.
- R5: If `iei_n` is low and nothing is pending when the cycle starts, `ieo_n` goes low from the next cycle. `dtack_n` stays high and no vector is driven.
- R6: The first clock edge at which `iack_n` is sampled high ends the cycle. In the next cycle `ieo_n` and `dtack_n` are high and `vec_oe` is low.
- R7: If `iei_n` is high when the cycle starts, the block drives no vector and no `dtack_n`, keeps `ieo_n` high, and leaves every pending flag untouched.
- R8: With `PROG_PRIO=1`, the pending source whose rank field `prio_rank[RW*i +: RW]` is numerically smallest wins. On equal ranks, the lower source index wins.
- R9: The winning vector is captured when the cycle starts. `vec_o` holds that value for the whole cycle, even if new events arrive or the ranks change.
- R10: With `PROG_PRIO=0`, the lower source index always wins. Source 2c is the FIFO-empty event of channel c+1 and source 2c+1 is its end-of-transmission event. So channel 1 outranks channel 2, and within a channel FIFO-empty outranks end-of-transmission.
- R11: After reset no flag is pending, `irq_req` is low, `dtack_n` and `ieo_n` are high, and `vec_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cause_set | input | N_SRC | One-cycle event per source |
| cause_clr | input | N_SRC | Host clear pulse per source |
| prio_rank | input | N_SRC*RW | Rank per source, smaller wins (ignored when fixed) |
| vec_tbl | input | N_SRC*VEC_W | Vector number per source |
| irq_req | output | 1 | Request, high while anything is pending (drives the pad pull-down) |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| iei_n | input | 1 | Chain enable in, active low |
| ieo_n | output | 1 | Chain enable out, active low |
| vec_o | output | VEC_W | Vector byte |
| vec_oe | output | 1 | Vector byte valid / drive enable |
| dtack_n | output | 1 | Transfer acknowledge, active low |

## Verification
The bench builds two copies side by side on one acknowledge and chain line. The first copy is the receive form, with nine sources and programmable rank. This brings reverse ranking, all-equal ranking, mid-cycle events and parity-error-sized index widths within reach. The second copy is the transmit form, with six sources and fixed order. Here both channel ordering and event ordering inside a channel are visible. Because the two copies share the acknowledge line, every cycle also checks that an idle copy passes the chain on while the other one answers.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SERVE = 2'd1,
      ST_PASS  = 2'd2,
      ST_HOLD  = 2'd3
   } ack_st_e;

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int N = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] cause_set,
   input  logic [N-1:0] cause_clr,
   input  logic [N-1:0] ack_clr,
   output logic [N-1:0] pend,
   output logic         irq_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~(cause_clr | ack_clr)) | cause_set;
   end

   assign irq_req = |pend;

   // R1
   set_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|cause_set) |=> irq_req);
   // R4
   ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_clr));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N         = 9,
   parameter bit PROG_PRIO = 1'b1,
   parameter int RW        = 4,
   parameter int IW        = 4
) (
   input  logic [N-1:0]    pend,
   input  logic [N*RW-1:0] rank,
   output logic            any,
   output logic [IW-1:0]   win
);
   assign any = |pend;

   generate
      if (PROG_PRIO) begin : g_prog
         logic [RW-1:0] best_rank;
         logic          found;
         always_comb begin
            found     = 1'b0;
            best_rank = '1;
            win       = '0;
            for (int i = 0; i < N; i++) begin
               if (pend[i] && (!found || rank[i*RW +: RW] < best_rank)) begin
                  found     = 1'b1;
                  best_rank = rank[i*RW +: RW];
                  win       = IW'(i);
               end
            end
         end
      end else begin : g_fixed
         logic unused_rank;
         assign unused_rank = ^rank;
         always_comb begin
            win = '0;
            for (int i = N-1; i >= 0; i--) begin
               if (pend[i]) win = IW'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
   import irq_pkg::*;
#(
   parameter int N     = 9,
   parameter int IW    = 4,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iack_n,
   input  logic             iei_n,
   input  logic             any,
   input  logic [IW-1:0]    win,
   input  logic [N*VEC_W-1:0] vec_tbl,
   output logic [N-1:0]     ack_clr,
   output logic [VEC_W-1:0] vec_o,
   output logic             vec_oe,
   output logic             dtack_n,
   output logic             ieo_n
);
   ack_st_e          st;
   logic [VEC_W-1:0] vec_q;
   logic [VEC_W-1:0] tbl [N];
   logic             start, grant;

   generate
      for (genvar g = 0; g < N; g++) begin : g_tbl
         assign tbl[g] = vec_tbl[g*VEC_W +: VEC_W];
      end
   endgenerate

   assign start = (st == ST_IDLE) && !iack_n;
   assign grant = start && !iei_n && any;

   always_comb begin
      for (int i = 0; i < N; i++) ack_clr[i] = grant && (win == IW'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         vec_q <= '0;
      end else begin
         case (st)
            ST_IDLE: if (!iack_n) begin
               if (iei_n)    st <= ST_HOLD;
               else if (any) begin
                  st    <= ST_SERVE;
                  vec_q <= tbl[win];
               end else      st <= ST_PASS;
            end
            default: if (iack_n) st <= ST_IDLE;
         endcase
      end
   end

   assign vec_oe  = (st == ST_SERVE);
   assign vec_o   = vec_oe ? vec_q : '0;
   assign dtack_n = !vec_oe;
   assign ieo_n   = (st != ST_PASS);

   // R3
   serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> (!dtack_n && vec_oe && ieo_n));
   // R5
   pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !iei_n && !any) |=> (!ieo_n && dtack_n && !vec_oe));
   // R6
   ack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iack_n |=> (ieo_n && dtack_n && !vec_oe));
   // R7
   blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && iei_n) |=> (dtack_n && ieo_n && !vec_oe));
   // R9
   vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dtack_n && !iack_n) |=> $stable(vec_o));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
   parameter int N_SRC     = 9,
   parameter bit PROG_PRIO = 1'b1,
   parameter int VEC_W     = 8,
   localparam int RW       = irq_pkg::idx_bits(N_SRC),
   localparam int IW       = irq_pkg::idx_bits(N_SRC)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_SRC-1:0]       cause_set,
   input  logic [N_SRC-1:0]       cause_clr,
   input  logic [N_SRC*RW-1:0]    prio_rank,
   input  logic [N_SRC*VEC_W-1:0] vec_tbl,
   output logic                   irq_req,
   input  logic                   iack_n,
   input  logic                   iei_n,
   output logic                   ieo_n,
   output logic [VEC_W-1:0]       vec_o,
   output logic                   vec_oe,
   output logic                   dtack_n
);
   generate
      if (N_SRC < 2 || N_SRC > 32) begin : g_bad_n
         $error("vec_irq_ctrl: N_SRC must lie in 2..32");
      end
      if (VEC_W < 1 || VEC_W > 16) begin : g_bad_w
         $error("vec_irq_ctrl: VEC_W must lie in 1..16");
      end
   endgenerate

   logic [N_SRC-1:0] pend, ack_clr;
   logic             any;
   logic [IW-1:0]    win;

   irq_pend_bank #(.N(N_SRC)) u_bank (
      .clk(clk), .rst_n(rst_n), .cause_set(cause_set), .cause_clr(cause_clr),
      .ack_clr(ack_clr), .pend(pend), .irq_req(irq_req));

   irq_prio_pick #(.N(N_SRC), .PROG_PRIO(PROG_PRIO), .RW(RW), .IW(IW)) u_pick (
      .pend(pend), .rank(prio_rank), .any(any), .win(win));

   irq_ack_fsm #(.N(N_SRC), .IW(IW), .VEC_W(VEC_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .iack_n(iack_n), .iei_n(iei_n), .any(any),
      .win(win), .vec_tbl(vec_tbl), .ack_clr(ack_clr), .vec_o(vec_o),
      .vec_oe(vec_oe), .dtack_n(dtack_n), .ieo_n(ieo_n));

   // R11
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (!irq_req || !rst_n));
endmodule

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int N0 = 9, RW0 = 4;
   localparam int N1 = 6, RW1 = 3;

   logic clk = 1'b0, rst_n = 1'b0, iack_n = 1'b1, iei_n = 1'b0;
   logic [N0-1:0] set0 = '0, clr0 = '0;
   logic [N1-1:0] set1 = '0, clr1 = '0;
   logic [N0*RW0-1:0] rank0;
   logic [N1*RW1-1:0] rank1 = '0;
   logic [N0*8-1:0] vt0;
   logic [N1*8-1:0] vt1;
   logic irq0, oe0, dt0, ieo0, irq1, oe1, dt1, ieo1;
   logic [7:0] vec0, vec1;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_irq_ctrl #(.N_SRC(N0), .PROG_PRIO(1'b1), .VEC_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .cause_set(set0), .cause_clr(clr0),
      .prio_rank(rank0), .vec_tbl(vt0), .irq_req(irq0), .iack_n(iack_n),
      .iei_n(iei_n), .ieo_n(ieo0), .vec_o(vec0), .vec_oe(oe0), .dtack_n(dt0));

   vec_irq_ctrl #(.N_SRC(N1), .PROG_PRIO(1'b0), .VEC_W(8)) u1 (
      .clk(clk), .rst_n(rst_n), .cause_set(set1), .cause_clr(clr1),
      .prio_rank(rank1), .vec_tbl(vt1), .irq_req(irq1), .iack_n(iack_n),
      .iei_n(iei_n), .ieo_n(ieo1), .vec_o(vec1), .vec_oe(oe1), .dtack_n(dt1));

   typedef struct {
      string      req;
      logic       dt0; logic [7:0] v0; logic ie0;
      logic       dt1; logic [7:0] v1; logic ie1;
   } exp_t;

   exp_t q[$];
   event ev_mon;
   int   n_tests = 0, n_fail = 0;
   bit   done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic exp_t mk(input string r, input logic d0, input logic [7:0] v0,
                               input logic i0, input logic d1, input logic [7:0] v1,
                               input logic i1);
      exp_t e;
      e.req = r; e.dt0 = d0; e.v0 = v0; e.ie0 = i0;
      e.dt1 = d1; e.v1 = v1; e.ie1 = i1;
      return e;
   endfunction

   // scoreboard monitor
   initial forever begin
      exp_t e;
      @(ev_mon);
      e = q.pop_front();
      chk(dt0 == e.dt0, e.req, "u0 dtack_n", int'(dt0), int'(e.dt0));
      chk(vec0 == e.v0, e.req, "u0 vec", int'(vec0), int'(e.v0));
      chk(ieo0 == e.ie0, e.req, "u0 ieo_n", int'(ieo0), int'(e.ie0));
      chk(dt1 == e.dt1, e.req, "u1 dtack_n", int'(dt1), int'(e.dt1));
      chk(vec1 == e.v1, e.req, "u1 vec", int'(vec1), int'(e.v1));
      chk(ieo1 == e.ie1, e.req, "u1 ieo_n", int'(ieo1), int'(e.ie1));
   end

   task automatic release_check();
      @(negedge clk); iack_n = 1'b1;
      @(posedge clk); @(negedge clk);
      // R6
      chk({dt0, ieo0, oe0} == 3'b110, "R6", "u0 end", int'({dt0, ieo0, oe0}), 6);
      chk({dt1, ieo1, oe1} == 3'b110, "R6", "u1 end", int'({dt1, ieo1, oe1}), 6);
      iei_n = 1'b0;
   endtask

   task automatic ack(input logic iei, input exp_t e);
      @(negedge clk); iei_n = iei; iack_n = 1'b0; q.push_back(e);
      @(posedge clk); @(negedge clk); ->ev_mon;
      release_check();
   endtask

   task automatic pset0(input logic [N0-1:0] m);
      @(negedge clk); set0 = m; @(negedge clk); set0 = '0;
   endtask
   task automatic pclr0(input logic [N0-1:0] m);
      @(negedge clk); clr0 = m; @(negedge clk); clr0 = '0;
   endtask
   task automatic pset1(input logic [N1-1:0] m);
      @(negedge clk); set1 = m; @(negedge clk); set1 = '0;
   endtask

   initial begin
      for (int i = 0; i < N0; i++) begin
         vt0[i*8 +: 8]       = 8'h40 + 8'(i);
         rank0[i*RW0 +: RW0] = RW0'(i);
      end
      for (int i = 0; i < N1; i++) vt1[i*8 +: 8] = 8'h80 + 8'(i);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk({irq0, dt0, ieo0, oe0} == 4'b0110, "R11", "u0 idle", int'({irq0, dt0, ieo0, oe0}), 6);
      chk({irq1, dt1, ieo1, oe1} == 4'b0110, "R11", "u1 idle", int'({irq1, dt1, ieo1, oe1}), 6);

      // R1 latch and request
      pset0(9'h008);
      chk(irq0 == 1'b1, "R1", "irq after set", int'(irq0), 1);
      repeat (2) @(negedge clk);
      chk(irq0 == 1'b1, "R1", "irq held", int'(irq0), 1);
      // R3 vector answer; u1 empty passes chain
      ack(1'b0, mk("R3", 1'b0, 8'h43, 1'b1, 1'b1, 8'h00, 1'b0));
      // R4 served flag cleared
      chk(irq0 == 1'b0, "R4", "irq after serve", int'(irq0), 0);

      // R5 nothing pending
      ack(1'b0, mk("R5", 1'b1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0));

      // R7 enable-in blocked
      pset0(9'h040);
      ack(1'b1, mk("R7", 1'b1, 8'h00, 1'b1, 1'b1, 8'h00, 1'b1));
      chk(irq0 == 1'b1, "R7", "pending kept", int'(irq0), 1);
      ack(1'b0, mk("R7", 1'b0, 8'h46, 1'b1, 1'b1, 8'h00, 1'b0));

      // R8 reverse ranking
      for (int i = 0; i < N0; i++) rank0[i*RW0 +: RW0] = RW0'(N0 - 1 - i);
      pset0(9'h084);
      ack(1'b0, mk("R8", 1'b0, 8'h47, 1'b1, 1'b1, 8'h00, 1'b0));
      ack(1'b0, mk("R8", 1'b0, 8'h42, 1'b1, 1'b1, 8'h00, 1'b0));
      // R8 equal ranks: lower index
      rank0 = '0;
      pset0(9'h012);
      ack(1'b0, mk("R8", 1'b0, 8'h41, 1'b1, 1'b1, 8'h00, 1'b0));
      ack(1'b0, mk("R8", 1'b0, 8'h44, 1'b1, 1'b1, 8'h00, 1'b0));

      // R2 host clear
      pset0(9'h020);
      pclr0(9'h020);
      chk(irq0 == 1'b0, "R2", "irq after clear", int'(irq0), 0);
      @(negedge clk); set0 = 9'h020; clr0 = 9'h020;
      @(negedge clk); set0 = '0; clr0 = '0;
      chk(irq0 == 1'b1, "R2", "set beats clear", int'(irq0), 1);
      ack(1'b0, mk("R2", 1'b0, 8'h45, 1'b1, 1'b1, 8'h00, 1'b0));

      // R9 vector stable while a new event arrives mid-cycle
      pset0(9'h100);
      @(negedge clk); iei_n = 1'b0; iack_n = 1'b0;
      q.push_back(mk("R9", 1'b0, 8'h48, 1'b1, 1'b1, 8'h00, 1'b0));
      @(posedge clk); @(negedge clk); ->ev_mon; set0 = 9'h001; rank0 = '1;
      @(negedge clk); set0 = '0;
      chk(vec0 == 8'h48, "R9", "vec mid", int'(vec0), 8'h48);
      @(negedge clk);
      chk(vec0 == 8'h48 && dt0 == 1'b0, "R9", "vec late", int'(vec0), 8'h48);
      release_check();
      ack(1'b0, mk("R9", 1'b0, 8'h40, 1'b1, 1'b1, 8'h00, 1'b0));

      // R10 fixed order on the transmit form
      pset1(6'b100110);
      ack(1'b0, mk("R10", 1'b1, 8'h00, 1'b0, 1'b0, 8'h81, 1'b1));
      ack(1'b0, mk("R10", 1'b1, 8'h00, 1'b0, 1'b0, 8'h82, 1'b1));
      ack(1'b0, mk("R10", 1'b1, 8'h00, 1'b0, 1'b0, 8'h85, 1'b1));
      chk(irq1 == 1'b0, "R10", "u1 drained", int'(irq1), 0);

      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule